// File: doc/BRIEF.md
# Dual-Source Wide Load Data Buffer

Two cores each have their own load-store unit, and both feed one shared floating-point cluster. Each core's port can hand over up to two 128-bit load data items per cycle, and every item carries a 6-bit destination tag. The buffer merges both streams into one 8-entry queue in arrival order. Each queue entry records the data, the tag and the core that sent the item.

Toward the cluster, the buffer shows the two oldest queued items on two output lanes. The cluster can therefore take at most 256 bits per cycle. When both cores deliver two items in the same cycle, the four items are spread over two consecutive output cycles and none is lost. Each input port has its own ready signal, which drops when the queue lacks room for that port's items.

Top module: `ldbuf_merge`

## Requirements
- R1: While `rst` is high on a clock edge, the queue is emptied. In the cycle after reset is released, `q_valid` is 2'b00, and both `s0_ready` and `s1_ready` are high when no item is offered.
- R2: Each input port has two item slots. Slot k uses bits [128k+127:128k] of the data bus and bits [6k+5:6k] of the tag bus. The slots are validated independently, so slot 1 may be offered alone. When both slots of one port are accepted in the same cycle, slot 0 is queued ahead of slot 1.
- R3: When both ports are accepted in the same cycle, every item from port 0 is queued ahead of every item from port 1.
- R4: Items leave in strict queue order. Lane 0 (bits [127:0] of `q_data`) always carries the oldest queued item, and lane 1 (bits [255:128]) carries the next oldest.
- R5: An item accepted on a clock edge becomes visible on the lanes from the next cycle. `q_valid[0]` is high when at least one item is queued, and `q_valid[1]` is high when at least two are queued. `q_valid[1]` is never high while `q_valid[0]` is low.
- R6: An item is removed only when its lane's valid and ready are both high and every older lane is also removed in that cycle. Consequences:
  - When only lane 0 is taken, exactly one item leaves, and the former lane 1 item appears on lane 0 in the next cycle.
  - A ready on lane 1 alone removes nothing.
- R7: When all four slots are offered into an empty queue and both lanes are always ready, two items leave in each of the next two cycles. No items are left after that.
- R8: The queue holds 8 entries. `s0_ready` is high exactly when the number of valid port 0 slots does not exceed the free entries. Free entries are counted as 8 minus the queued items, ignoring items leaving in the same cycle.
- R9: `s1_ready` is high exactly when the items accepted from port 0 in that cycle plus the valid port 1 slots do not exceed the free entries, counted as in R8.
- R10: Each output lane carries its item's tag unchanged on `q_tag` (6 bits per lane, lane k at [6k+5:6k]). It also carries a source bit on `q_src[k]`, which is 0 for items from port 0 and 1 for items from port 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_valid | input | 2 | Per-slot valid, port 0 |
| s0_ready | output | 1 | Port 0 may transfer all its valid slots this cycle |
| s0_data | input | 256 | Two 128-bit load data slots, port 0 |
| s0_tag | input | 12 | Two 6-bit destination tags, port 0 |
| s1_valid | input | 2 | Per-slot valid, port 1 |
| s1_ready | output | 1 | Port 1 may transfer all its valid slots this cycle |
| s1_data | input | 256 | Two 128-bit load data slots, port 1 |
| s1_tag | input | 12 | Two 6-bit destination tags, port 1 |
| q_valid | output | 2 | Per-lane valid toward the shared cluster |
| q_ready | input | 2 | Per-lane ready from the shared cluster |
| q_data | output | 256 | Two 128-bit output lanes, lane 0 oldest |
| q_tag | output | 12 | Tag of each output lane |
| q_src | output | 2 | Source port of each output lane |

## Verification
Every combination of slot valids on both ports is offered into an empty queue and then drained. This separates slot order within a port from port order across ports, and it covers the four-item burst.

At each occupancy from empty to full, all sixteen valid combinations are held long enough to read both readies and then withdrawn. This separates port 0's own space test from port 1's test, which depends on port 0's acceptance.

Partial drains take lane 0 alone or offer lane 1 alone. They show whether single removal shifts lane 1 down and whether lane 1's ready is wrongly honoured.

A long pseudo-random mix of offers and drains checks data, tag and source against an arithmetic queue model on every cycle.

// File: rtl/ldbuf_pkg.sv
package ldbuf_pkg;

    localparam int unsigned LD_DATA_W = 128;
    localparam int unsigned LD_TAG_W  = 6;

    localparam logic SRC_PORT0 = 1'b0;
    localparam logic SRC_PORT1 = 1'b1;

    typedef struct packed {
        logic [LD_DATA_W-1:0] data;
        logic [LD_TAG_W-1:0]  tag;
        logic                 src;
    } ld_item_t;

    // Width of a counter that must hold values 0..limit.
    function automatic int unsigned count_width(input int unsigned limit);
        return $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/ldbuf_admit.sv
// Admission: decides per-port readiness and the queue offset of every accepted slot.
module ldbuf_admit #(
    parameter  int unsigned DEPTH = 8,
    parameter  int unsigned SLOTS = 2,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned NIN   = 2 * SLOTS
) (
    input  logic [CNT_W-1:0] occ,
    input  logic [SLOTS-1:0] p0_valid,
    input  logic [SLOTS-1:0] p1_valid,
    output logic             p0_ready,
    output logic             p1_ready,
    output logic [NIN-1:0]   take,
    output logic [PTR_W-1:0] take_off [NIN],
    output logic [CNT_W-1:0] push_n
);

    logic [CNT_W-1:0] cnt0;
    logic [CNT_W-1:0] cnt1;
    logic [CNT_W-1:0] free_n;
    logic [CNT_W-1:0] acc0;
    logic [CNT_W-1:0] run;

    always_comb begin
        cnt0 = '0;
        cnt1 = '0;
        for (int k = 0; k < SLOTS; k++) begin
            cnt0 = cnt0 + CNT_W'(p0_valid[k]);
            cnt1 = cnt1 + CNT_W'(p1_valid[k]);
        end
        free_n   = CNT_W'(DEPTH) - occ;
        // port 0 has priority; port 1 sees the space left after port 0
        p0_ready = (cnt0 <= free_n);
        acc0     = p0_ready ? cnt0 : '0;
        p1_ready = ((acc0 + cnt1) <= free_n);
        for (int k = 0; k < SLOTS; k++) begin
            take[k]         = p0_valid[k] & p0_ready;
            take[SLOTS + k] = p1_valid[k] & p1_ready;
        end
        run = '0;
        for (int k = 0; k < NIN; k++) begin
            take_off[k] = PTR_W'(run);
            run         = run + CNT_W'(take[k]);
        end
        push_n = run;
    end

endmodule

// File: rtl/ldbuf_ring.sv
// Circular storage with multi-write tail and multi-lane head view. DEPTH must be a power of two.
module ldbuf_ring
    import ldbuf_pkg::*;
#(
    parameter  int unsigned DEPTH = 8,
    parameter  int unsigned NIN   = 4,
    parameter  int unsigned LANES = 2,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIN-1:0]   wr_en,
    input  logic [PTR_W-1:0] wr_off  [NIN],
    input  ld_item_t         wr_item [NIN],
    input  logic [CNT_W-1:0] push_n,
    input  logic [CNT_W-1:0] pop_n,
    output logic [CNT_W-1:0] occ,
    output ld_item_t         lane_item [LANES],
    output logic [LANES-1:0] lane_valid
);

    ld_item_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] occ_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_n);
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            occ_q  <= occ_q + push_n - pop_n;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NIN; k++) begin
            if (wr_en[k]) begin
                mem[wr_ptr + wr_off[k]] <= wr_item[k];
            end
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_item[i]  = mem[rd_ptr + PTR_W'(i)];
        assign lane_valid[i] = (occ_q > CNT_W'(i));
    end

    assign occ = occ_q;

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        ((CNT_W + 1)'(occ_q) + (CNT_W + 1)'(push_n)) <= (CNT_W + 1)'(DEPTH));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        pop_n <= occ_q);

endmodule

// File: rtl/ldbuf_drain.sv
// Drain: counts the in-order prefix of lanes the consumer takes this cycle.
module ldbuf_drain #(
    parameter int unsigned LANES = 2,
    parameter int unsigned CNT_W = 4
) (
    input  logic [LANES-1:0] lane_valid,
    input  logic [LANES-1:0] lane_ready,
    output logic [CNT_W-1:0] pop_n
);

    logic run;

    always_comb begin
        pop_n = '0;
        run   = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (run && lane_valid[i] && lane_ready[i]) begin
                pop_n = pop_n + 1'b1;
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/ldbuf_merge.sv
module ldbuf_merge
    import ldbuf_pkg::*;
#(
    parameter  int unsigned DEPTH = 8,
    parameter  int unsigned SLOTS = 2,
    parameter  int unsigned LANES = 2,
    localparam int unsigned DW    = LD_DATA_W,
    localparam int unsigned TW    = LD_TAG_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SLOTS-1:0]      s0_valid,
    output logic                  s0_ready,
    input  logic [SLOTS*DW-1:0]   s0_data,
    input  logic [SLOTS*TW-1:0]   s0_tag,
    input  logic [SLOTS-1:0]      s1_valid,
    output logic                  s1_ready,
    input  logic [SLOTS*DW-1:0]   s1_data,
    input  logic [SLOTS*TW-1:0]   s1_tag,
    output logic [LANES-1:0]      q_valid,
    input  logic [LANES-1:0]      q_ready,
    output logic [LANES*DW-1:0]   q_data,
    output logic [LANES*TW-1:0]   q_tag,
    output logic [LANES-1:0]      q_src
);

    localparam int unsigned CNT_W = count_width(DEPTH);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned NIN   = 2 * SLOTS;

    ld_item_t         in_item [NIN];
    logic [NIN-1:0]   take;
    logic [PTR_W-1:0] take_off [NIN];
    logic [CNT_W-1:0] push_n;
    logic [CNT_W-1:0] pop_n;
    logic [CNT_W-1:0] occ;
    ld_item_t         lane_item [LANES];

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign in_item[k] = '{data: s0_data[k*DW +: DW],
                              tag:  s0_tag[k*TW +: TW],
                              src:  SRC_PORT0};
        assign in_item[SLOTS + k] = '{data: s1_data[k*DW +: DW],
                                      tag:  s1_tag[k*TW +: TW],
                                      src:  SRC_PORT1};
    end

    ldbuf_admit #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_admit (
        .occ      (occ),
        .p0_valid (s0_valid),
        .p1_valid (s1_valid),
        .p0_ready (s0_ready),
        .p1_ready (s1_ready),
        .take     (take),
        .take_off (take_off),
        .push_n   (push_n)
    );

    ldbuf_ring #(.DEPTH(DEPTH), .NIN(NIN), .LANES(LANES)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (take),
        .wr_off     (take_off),
        .wr_item    (in_item),
        .push_n     (push_n),
        .pop_n      (pop_n),
        .occ        (occ),
        .lane_item  (lane_item),
        .lane_valid (q_valid)
    );

    ldbuf_drain #(.LANES(LANES), .CNT_W(CNT_W)) u_drain (
        .lane_valid (q_valid),
        .lane_ready (q_ready),
        .pop_n      (pop_n)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_out
        assign q_data[i*DW +: DW] = lane_item[i].data;
        assign q_tag[i*TW +: TW]  = lane_item[i].tag;
        assign q_src[i]           = lane_item[i].src;
    end

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q_valid == '0));

    for (genvar i = 1; i < LANES; i++) begin : g_prefix
        assert_lane_prefix_R5: assert property (@(posedge clk) disable iff (rst)
            q_valid[i] |-> q_valid[i-1]);
    end

    assert_head_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (q_valid[0] && !q_ready[0]) |=>
            (q_valid[0] && (q_data[DW-1:0] == $past(q_data[DW-1:0]))
                        && (q_tag[TW-1:0] == $past(q_tag[TW-1:0]))));

    if (LANES >= 2) begin : g_shift
        assert_single_shift_R6: assert property (@(posedge clk) disable iff (rst)
            (q_valid[1] && q_ready[0] && !q_ready[1]) |=>
                (q_valid[0] && (q_data[DW-1:0] == $past(q_data[2*DW-1:DW]))
                            && (q_tag[TW-1:0] == $past(q_tag[2*TW-1:TW]))
                            && (q_src[0] == $past(q_src[1]))));
    end

endmodule

// File: tb/ldbuf_merge_test.sv
module ldbuf_merge_test;

    localparam int DW    = 128;
    localparam int TW    = 6;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   s0_valid, s1_valid, q_valid, q_ready, q_src;
    logic         s0_ready, s1_ready;
    logic [255:0] s0_data, s1_data, q_data;
    logic [11:0]  s0_tag, s1_tag, q_tag;

    always #10 clk = ~clk;

    ldbuf_merge uut (
        .clk(clk), .rst(rst),
        .s0_valid(s0_valid), .s0_ready(s0_ready), .s0_data(s0_data), .s0_tag(s0_tag),
        .s1_valid(s1_valid), .s1_ready(s1_ready), .s1_data(s1_data), .s1_tag(s1_tag),
        .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data), .q_tag(q_tag), .q_src(q_src)
    );

    int errs = 0;
    int checks = 0;
    int ser = 0;
    int q_ser [16];
    int q_sid [16];
    int qh = 0;
    int qc = 0;

    function automatic logic [127:0] mk_data(input int s);
        return {32'(s) ^ 32'hC0DE_0000, 32'(s * 7 + 1), ~32'(s), 32'(s)};
    endfunction

    function automatic logic [5:0] mk_tag(input int s);
        return 6'(s * 5 + 3);
    endfunction

    task automatic chk(input bit ok, input string msg, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", msg, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] av, input logic [1:0] bv, input logic [1:0] ordy);
        s0_valid = av;
        s1_valid = bv;
        q_ready  = ordy;
        s0_data  = {mk_data(ser + 1), mk_data(ser)};
        s0_tag   = {mk_tag(ser + 1), mk_tag(ser)};
        s1_data  = {mk_data(ser + 3), mk_data(ser + 2)};
        s1_tag   = {mk_tag(ser + 3), mk_tag(ser + 2)};
    endtask

    task automatic push_model(input int s, input int sid);
        q_ser[(qh + qc) % 16] = s;
        q_sid[(qh + qc) % 16] = sid;
        qc++;
    endtask

    // One cycle: drive, check readies and lanes against the queue model, update the model.
    task automatic step(input logic [1:0] av, input logic [1:0] bv, input logic [1:0] ordy);
        int  free_n, ca, cb, acc, pn, idx;
        bit  ea, eb;
        @(negedge clk);
        drive(av, bv, ordy);
        #1;
        free_n = DEPTH - qc;
        ca  = $countones(av);
        cb  = $countones(bv);
        ea  = (ca <= free_n);
        acc = ea ? ca : 0;
        eb  = ((acc + cb) <= free_n);
        chk(s0_ready == ea, "R8 port 0 ready", 128'(s0_ready), 128'(ea));
        chk(s1_ready == eb, "R9 port 1 ready", 128'(s1_ready), 128'(eb));
        chk(q_valid == {qc >= 2, qc >= 1}, "R5 lane valids", 128'(q_valid), 128'({qc >= 2, qc >= 1}));
        for (int i = 0; i < 2; i++) begin
            if (qc > i) begin
                idx = (qh + i) % 16;
                chk(q_data[i*DW +: DW] == mk_data(q_ser[idx]), "R4 R2 R3 R6 lane data order",
                    q_data[i*DW +: DW], mk_data(q_ser[idx]));
                chk(q_tag[i*TW +: TW] == mk_tag(q_ser[idx]), "R10 lane tag",
                    128'(q_tag[i*TW +: TW]), 128'(mk_tag(q_ser[idx])));
                chk(q_src[i] == 1'(q_sid[idx]), "R10 lane source",
                    128'(q_src[i]), 128'(q_sid[idx]));
            end
        end
        pn = 0;
        if (ordy[0] && qc >= 1) begin
            pn = 1;
            if (ordy[1] && qc >= 2) pn = 2;
        end
        qh = (qh + pn) % 16;
        qc = qc - pn;
        if (ea) for (int k = 0; k < 2; k++) if (av[k]) push_model(ser + k, 0);
        if (eb) for (int k = 0; k < 2; k++) if (bv[k]) push_model(ser + 2 + k, 1);
        ser += 4;
    endtask

    // Read both readies for a valid pattern without letting it cross a clock edge.
    task automatic probe(input logic [1:0] av, input logic [1:0] bv);
        int free_n, ca, acc;
        bit ea, eb;
        @(negedge clk);
        drive(av, bv, 2'b00);
        #1;
        free_n = DEPTH - qc;
        ca  = $countones(av);
        ea  = (ca <= free_n);
        acc = ea ? ca : 0;
        eb  = ((acc + $countones(bv)) <= free_n);
        chk(s0_ready == ea, "R8 port 0 space at occupancy", 128'(s0_ready), 128'(ea));
        chk(s1_ready == eb, "R9 port 1 space after port 0", 128'(s1_ready), 128'(eb));
        drive(2'b00, 2'b00, 2'b00);
    endtask

    task automatic drain_all();
        while (qc > 0) step(2'b00, 2'b00, 2'b11);
        step(2'b00, 2'b00, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog R4 actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        drive(2'b00, 2'b00, 2'b00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(q_valid == 2'b00, "R1 lanes empty after reset", 128'(q_valid), 128'(0));
        chk(s0_ready == 1'b1, "R1 port 0 ready after reset", 128'(s0_ready), 128'(1));
        chk(s1_ready == 1'b1, "R1 port 1 ready after reset", 128'(s1_ready), 128'(1));

        // every slot-valid combination into an empty queue (R2, R3, R7)
        for (int av = 0; av < 4; av++) begin
            for (int bv = 0; bv < 4; bv++) begin
                step(2'(av), 2'(bv), 2'b00);
                step(2'b00, 2'b00, 2'b11);
                step(2'b00, 2'b00, 2'b11);
                if (av == 3 && bv == 3) begin
                    @(negedge clk);
                    #1;
                    chk(q_valid == 2'b00, "R7 four-item burst released over two cycles",
                        128'(q_valid), 128'(0));
                end
                step(2'b00, 2'b00, 2'b00);
            end
        end

        // readiness at every occupancy (R8, R9)
        for (int k = 0; k <= DEPTH; k++) begin
            drain_all();
            while (qc < k) step((k - qc >= 2) ? 2'b11 : 2'b01, 2'b00, 2'b00);
            for (int av = 0; av < 4; av++)
                for (int bv = 0; bv < 4; bv++)
                    probe(2'(av), 2'(bv));
        end
        drain_all();

        // single-lane removal and lane 1 ready alone (R6)
        step(2'b11, 2'b11, 2'b00);
        step(2'b11, 2'b00, 2'b00);
        step(2'b00, 2'b00, 2'b10);
        step(2'b00, 2'b00, 2'b10);
        for (int n = 0; n < 7; n++) step(2'b00, 2'b00, 2'b01);
        step(2'b00, 2'b00, 2'b00);

        // reset mid-run empties the queue (R1)
        step(2'b11, 2'b01, 2'b00);
        @(negedge clk);
        drive(2'b00, 2'b00, 2'b00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        qh = 0;
        qc = 0;
        #1;
        chk(q_valid == 2'b00, "R1 queue emptied by reset", 128'(q_valid), 128'(0));

        // mixed pseudo-random traffic
        lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[1:0], lf[3:2], (lf[5:4] == 2'b00) ? 2'b01 : lf[7:6] | 2'b01);
        end
        drain_all();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule